// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block carries out one multi-register block transfer. It moves any subset of sixteen 32-bit registers to or from a run of consecutive memory words. A start pulse brings in five things: a direction, a 3-bit addressing mode, a base address, a 16-bit register selection mask and a writeback flag. The block then makes one word access per selected register over a request/ready memory port. Stores take their data from a combinational register-file read port. Loads hand each returned word to a register-file write port.

Every mode works the same way inside. At start the block computes the lowest address of the block and the final base value. It then visits the selected registers from the lowest number upward, with the address rising by 4 on each access. Four of the modes are plain block modes. The other four are stack aliases, and each alias resolves to a different block mode for a load than for a store. As a result, a push done with an alias is undone by a pop done with the same alias.

Top module: `blk_xfer_seq`

## Requirements
- R1: `mode_i` values 0..3 select the block modes. 0 is increment-after: the lowest address is the base. 1 is increment-before: the lowest address is base+4. 2 is decrement-after: the lowest address is base-4n+4. 3 is decrement-before: the lowest address is base-4n. Here n is the number of set mask bits.
- R2: `mode_i` values 4..7 are stack aliases, resolved as (store, load). 4 is full-descending and maps to (decrement-before, increment-after). 5 is full-ascending and maps to (increment-before, decrement-after). 6 is empty-descending and maps to (decrement-after, increment-before). 7 is empty-ascending and maps to (increment-after, decrement-before).
- R3: Exactly one 32-bit access is made per set mask bit. The accesses go in ascending register number, from the lowest address upward in steps of 4. Register r therefore sits at the lowest address plus 4 times the number of selected registers below r.
- R4: With `dir_i`=1 (store), each selected register's value, read through `rf_rd_idx_o`/`rf_rd_data_i`, is written to its memory word. No other memory word changes.
- R5: With `dir_i`=0 (load), each selected register receives its memory word through `rf_we_o`/`rf_wr_idx_o`/`rf_wr_data_o`. No other register changes.
- R6: When `wb_i` is set, `base_we_o` pulses together with `done_o`. At that point `base_o` is base+4n for modes resolving to increment-after or increment-before, and base-4n for the decrement modes. When `wb_i` is clear, `base_we_o` stays low.
- R7: While `mem_req_o` is high and `mem_rdy_i` is low, the address, write enable and write data hold steady. Only one access is in flight at a time.
- R8: An all-zero mask makes no memory access. It asserts `done_o` in the first cycle after the start edge, and a requested writeback returns the base unchanged.
- R9: `busy_o` is high from the cycle after an accepted start through the single-cycle `done_o` pulse. It is low in the cycle after that pulse.
- R10: A start asserted while `busy_o` is high has no effect on the running transfer or its access count.
- R11: A full-descending store of registers 1..3 with writeback, followed by a full-descending load of registers 1..3 from the returned base, restores all three registers and returns the original base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| dir_i | input | 1 | 1 = store registers to memory, 0 = load |
| mode_i | input | 3 | Addressing mode, encoded as in R1/R2 |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register selection mask, bit r selects register r |
| wb_i | input | 1 | Request writeback of the updated base |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Single-cycle completion pulse |
| base_we_o | output | 1 | Updated base valid, pulses with done when writeback was requested |
| base_o | output | 32 | Updated base value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_rdy_i | input | 1 | Memory accepts or completes the request |
| rf_rd_idx_o | output | 4 | Register-file read index |
| rf_rd_data_i | input | 32 | Register-file read data, combinational |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wr_idx_o | output | 4 | Register-file write index |
| rf_wr_data_o | output | 32 | Register-file write data |

## Verification
The sweep covers all eight mode codes in both directions. Each combination runs against a set of masks: empty, a single low bit, a single high bit, a contiguous run, all ones, and two scattered patterns. The single-bit masks separate the before and after variants at the block's edge. The scattered masks show whether registers are packed by ascending number without gaps. The all-ones mask exercises the widest address span in both directions. Running the same mode code once as a load and once as a store separates the two halves of each stack alias. A full-descending push followed by a pop from the returned base then confirms the two halves are inverses. A memory ready signal that stalls irregularly, together with a start pulse injected mid-transfer, probes the stable-request and ignored-start rules.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int NREG       = 16;
    localparam int WORD_BYTES = 4;

    // Plain walk modes after alias resolution
    typedef enum logic [1:0] {
        BM_INC_AFTER  = 2'd0,
        BM_INC_BEFORE = 2'd1,
        BM_DEC_AFTER  = 2'd2,
        BM_DEC_BEFORE = 2'd3
    } blk_mode_e;

    // Encoding of mode_i at the ports
    typedef enum logic [2:0] {
        AM_IA = 3'd0,
        AM_IB = 3'd1,
        AM_DA = 3'd2,
        AM_DB = 3'd3,
        AM_FD = 3'd4,
        AM_FA = 3'd5,
        AM_ED = 3'd6,
        AM_EA = 3'd7
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] first_addr;
        logic [ADDR_W-1:0] final_base;
    } addr_plan_t;

    // Map a port mode code plus direction to a plain walk mode
    function automatic blk_mode_e resolve_mode(input logic [2:0] code, input logic is_store);
        blk_mode_e m;
        case (addr_mode_e'(code))
            AM_IA:   m = BM_INC_AFTER;
            AM_IB:   m = BM_INC_BEFORE;
            AM_DA:   m = BM_DEC_AFTER;
            AM_DB:   m = BM_DEC_BEFORE;
            AM_FD:   m = is_store ? BM_DEC_BEFORE : BM_INC_AFTER;
            AM_FA:   m = is_store ? BM_INC_BEFORE : BM_DEC_AFTER;
            AM_ED:   m = is_store ? BM_DEC_AFTER  : BM_INC_BEFORE;
            default: m = is_store ? BM_INC_AFTER  : BM_DEC_BEFORE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/blk_addr_plan.sv
module blk_addr_plan
    import blk_xfer_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int NR   = NREG,
    parameter int STEP = WORD_BYTES
) (
    input  logic [AW-1:0] base,
    input  logic [NR-1:0] mask,
    input  blk_mode_e     mode,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] final_base
);
    localparam int CNT_W = $clog2(NR + 1);

    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    span;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NR; i++) begin
            cnt = cnt + CNT_W'(mask[i]);
        end
    end

    assign span = AW'(cnt) * AW'(STEP);

    always_comb begin
        case (mode)
            BM_INC_AFTER: begin
                first_addr = base;
                final_base = base + span;
            end
            BM_INC_BEFORE: begin
                first_addr = base + AW'(STEP);
                final_base = base + span;
            end
            BM_DEC_AFTER: begin
                first_addr = base - span + AW'(STEP);
                final_base = base - span;
            end
            default: begin
                first_addr = base - span;
                final_base = base - span;
            end
        endcase
    end
endmodule

// File: rtl/blk_low_sel.sv
module blk_low_sel #(
    parameter int NR    = 16,
    parameter int IDX_W = $clog2(NR)
) (
    input  logic [NR-1:0]    pend,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    always_comb begin
        idx = '0;
        for (int i = NR - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    assign last = ((pend & (pend - NR'(1))) == '0);
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int NR   = NREG,
    parameter int STEP = WORD_BYTES,
    localparam int IDX_W = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [2:0]       mode_i,
    input  logic [AW-1:0]    base_i,
    input  logic [NR-1:0]    mask_i,
    input  logic             wb_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             base_we_o,
    output logic [AW-1:0]    base_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [DW-1:0]    mem_rdata_i,
    input  logic             mem_rdy_i,
    output logic [IDX_W-1:0] rf_rd_idx_o,
    input  logic [DW-1:0]    rf_rd_data_i,
    output logic             rf_we_o,
    output logic [IDX_W-1:0] rf_wr_idx_o,
    output logic [DW-1:0]    rf_wr_data_o
);
    seq_state_e        state_q;
    logic [NR-1:0]     pend_q;
    logic [AW-1:0]     addr_q;
    logic [AW-1:0]     final_q;
    logic              store_q;
    logic              wb_q;

    blk_mode_e         walk_mode;
    logic [AW-1:0]     plan_first;
    logic [AW-1:0]     plan_final;
    logic [IDX_W-1:0]  cur_idx;
    logic              cur_last;
    logic              beat;

    assign walk_mode = resolve_mode(mode_i, dir_i);

    blk_addr_plan #(.AW(AW), .NR(NR), .STEP(STEP)) i_plan (
        .base       (base_i),
        .mask       (mask_i),
        .mode       (walk_mode),
        .first_addr (plan_first),
        .final_base (plan_final)
    );

    blk_low_sel #(.NR(NR), .IDX_W(IDX_W)) i_sel (
        .pend (pend_q),
        .idx  (cur_idx),
        .last (cur_last)
    );

    assign beat = (state_q == ST_XFER) && mem_rdy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            final_q <= '0;
            store_q <= 1'b0;
            wb_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        pend_q  <= mask_i;
                        addr_q  <= plan_first;
                        final_q <= plan_final;
                        store_q <= dir_i;
                        wb_q    <= wb_i;
                        state_q <= (mask_i == '0) ? ST_FIN : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (beat) begin
                        pend_q <= pend_q & (pend_q - NR'(1));
                        addr_q <= addr_q + AW'(STEP);
                        if (cur_last) state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = (state_q == ST_FIN);
    assign base_we_o    = done_o && wb_q;
    assign base_o       = final_q;

    assign mem_req_o    = (state_q == ST_XFER);
    assign mem_we_o     = mem_req_o && store_q;
    assign mem_addr_o   = addr_q;
    assign mem_wdata_o  = rf_rd_data_i;
    assign rf_rd_idx_o  = cur_idx;

    assign rf_we_o      = beat && !store_q;
    assign rf_wr_idx_o  = cur_idx;
    assign rf_wr_data_o = mem_rdata_i;
endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk #(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int NR   = 16,
    parameter int STEP = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [NR-1:0] mask_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          base_we_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          mem_rdy_i,
    input logic          rf_we_o
);
    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_rdy_i) |=> (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(STEP))));

    // R8
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && (mask_i == '0)) |=> (done_o && !mem_req_o));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    // R5
    rf_write_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> (mem_req_o && mem_rdy_i && !mem_we_o));

    // R6
    base_we_chk: assert property (@(posedge clk) disable iff (rst)
        base_we_o |-> done_o);

    // R7
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (busy_o && !done_o));
endmodule

bind blk_xfer_seq blk_xfer_chk #(.AW(AW), .DW(DW), .NR(NR), .STEP(STEP)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .mask_i      (mask_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .base_we_o   (base_we_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdy_i   (mem_rdy_i),
    .rf_we_o     (rf_we_o)
);

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        dir_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [31:0] base_i = '0;
    logic [15:0] mask_i = '0;
    logic        wb_i = 1'b0;
    logic        busy_o, done_o, base_we_o;
    logic [31:0] base_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        mem_rdy_i;
    logic [3:0]  rf_rd_idx_o, rf_wr_idx_o;
    logic [31:0] rf_rd_data_i, rf_wr_data_o;
    logic        rf_we_o;

    logic [31:0] rf  [16];
    logic [31:0] mem [256];
    logic [31:0] exp_rf  [16];
    logic [31:0] exp_mem [256];
    logic [7:0]  lfsr = 8'h5B;
    int          xfer_cnt = 0;
    int          op_cnt0  = 0;
    logic [31:0] first_addr = '0;
    int          n_checks = 0;
    int          n_errors = 0;

    always #10 clk = ~clk;

    blk_xfer_seq i_blk_xfer_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i), .mode_i(mode_i),
        .base_i(base_i), .mask_i(mask_i), .wb_i(wb_i), .busy_o(busy_o),
        .done_o(done_o), .base_we_o(base_we_o), .base_o(base_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i),
        .rf_rd_idx_o(rf_rd_idx_o), .rf_rd_data_i(rf_rd_data_i), .rf_we_o(rf_we_o),
        .rf_wr_idx_o(rf_wr_idx_o), .rf_wr_data_o(rf_wr_data_o)
    );

    assign mem_rdata_i  = mem[mem_addr_o[9:2]];
    assign rf_rd_data_i = rf[rf_rd_idx_o];
    assign mem_rdy_i    = lfsr[0] | lfsr[2];

    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

    always @(posedge clk) begin
        if (rf_we_o) rf[rf_wr_idx_o] <= rf_wr_data_o;
        if (mem_req_o && mem_rdy_i) begin
            if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
            if (xfer_cnt == op_cnt0) first_addr <= mem_addr_o;
            xfer_cnt <= xfer_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] walk_of(input logic [2:0] m, input logic st);
        logic [1:0] w;
        case (m)
            3'd0: w = 2'd0;
            3'd1: w = 2'd1;
            3'd2: w = 2'd2;
            3'd3: w = 2'd3;
            3'd4: w = st ? 2'd3 : 2'd0;
            3'd5: w = st ? 2'd1 : 2'd2;
            3'd6: w = st ? 2'd2 : 2'd1;
            default: w = st ? 2'd0 : 2'd3;
        endcase
        return w;
    endfunction

    task automatic fill(input int seed);
        for (int r = 0; r < 16; r++) rf[r] = 32'hA000_0000 + (seed << 8) + r;
        for (int i = 0; i < 256; i++) mem[i] = 32'h5000_0000 + (seed << 12) + i;
    endtask

    task automatic run_op(input logic d, input logic [2:0] m, input logic [31:0] b,
                          input logic [15:0] k, input logic w, input bit intrude);
        int n, cycles, pos;
        logic [1:0] wm;
        logic [31:0] low, exp_base;
        string tag;
        tag = (m < 3'd4) ? "R1" : "R2";
        n = $countones(k);
        wm = walk_of(m, d);
        case (wm)
            2'd0: low = b;
            2'd1: low = b + 4;
            2'd2: low = b - 32'(4 * n) + 4;
            default: low = b - 32'(4 * n);
        endcase
        exp_base = (wm < 2'd2) ? b + 32'(4 * n) : b - 32'(4 * n);
        for (int r = 0; r < 16; r++) exp_rf[r] = rf[r];
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        pos = 0;
        for (int r = 0; r < 16; r++) begin
            if (k[r]) begin
                if (d) exp_mem[(low[9:2] + 8'(pos))] = rf[r];
                else   exp_rf[r] = mem[(low[9:2] + 8'(pos))];
                pos++;
            end
        end
        op_cnt0 = xfer_cnt;
        @(negedge clk);
        dir_i = d; mode_i = m; base_i = b; mask_i = k; wb_i = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cycles = 1;
        // R9: busy from the cycle after the accepted start
        chk(busy_o == 1'b1, "R9 busy after start", 32'(busy_o), 32'd1);
        if (k == 16'h0) chk(done_o == 1'b1, "R8 done one cycle after start", 32'(done_o), 32'd1);
        while (!done_o && cycles < 3000) begin
            if (intrude && cycles == 1) begin
                start_i = 1'b1; mask_i = 16'hFFFF; dir_i = ~d; mode_i = 3'd1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        start_i = 1'b0;
        chk(cycles < 3000, "R9 completion timeout", 32'(cycles), 32'd0);
        // R6: writeback value and strobe
        chk(base_we_o == w, "R6 base strobe", 32'(base_we_o), 32'(w));
        if (w) chk(base_o == exp_base, "R6 base value", base_o, exp_base);
        if (k == 16'h0 && w) chk(base_o == b, "R8 base unchanged", base_o, b);
        @(negedge clk);
        chk(!done_o && !busy_o, "R9 done single cycle", {30'd0, done_o, busy_o}, 32'd0);
        // R3 / R10: one access per selected register, intruding start ignored
        chk(xfer_cnt - op_cnt0 == n, intrude ? "R10 access count" : "R3 access count",
            32'(xfer_cnt - op_cnt0), 32'(n));
        if (n > 0) chk(first_addr == low, tag, first_addr, low);
        for (int r = 0; r < 16; r++)
            chk(rf[r] == exp_rf[r], d ? "R4 register untouched" : "R5 load data", rf[r], exp_rf[r]);
        for (int i = 96; i < 160; i++)
            chk(mem[i] == exp_mem[i], d ? "R4 store data" : "R5 memory untouched", mem[i], exp_mem[i]);
    endtask

    initial begin
        logic [15:0] masks [7];
        logic [31:0] saved [4];
        logic [31:0] pushed_base;
        masks[0] = 16'h0000; masks[1] = 16'h0001; masks[2] = 16'h8000; masks[3] = 16'h000E;
        masks[4] = 16'hFFFF; masks[5] = 16'hA5A5; masks[6] = 16'h0330;
        fill(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_o && !rf_we_o && !base_we_o, "R9 reset state",
            {27'd0, busy_o, done_o, mem_req_o, rf_we_o, base_we_o}, 32'd0);
        for (int d = 0; d < 2; d++) begin
            for (int m = 0; m < 8; m++) begin
                for (int k = 0; k < 7; k++) begin
                    fill(d * 64 + m * 8 + k);
                    run_op(d[0], m[2:0], 32'h0000_0200, masks[k], k[0], (k == 5) || (k == 4));
                end
            end
        end
        // R11: full-descending push then pop restores registers 1..3
        fill(200);
        for (int r = 1; r < 4; r++) saved[r] = rf[r];
        run_op(1'b1, 3'd4, 32'h0000_0200, 16'h000E, 1'b1, 1'b0);
        pushed_base = base_o;
        chk(pushed_base == 32'h0000_01F4, "R11 pushed base", pushed_base, 32'h0000_01F4);
        for (int r = 1; r < 4; r++) rf[r] = 32'h0;
        run_op(1'b0, 3'd4, pushed_base, 16'h000E, 1'b1, 1'b0);
        chk(base_o == 32'h0000_0200, "R11 popped base", base_o, 32'h0000_0200);
        for (int r = 1; r < 4; r++) chk(rf[r] == saved[r], "R11 restored register", rf[r], saved[r]);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule